// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32. A simple register bus with single-cycle reads and writes gives per-pin control of direction and output value, a synchronized view of the pin levels, independent rising and falling edge detection, and a sticky edge-status word that feeds one combined interrupt line.

Registers are grouped by function. Each function occupies `NUM_PINS/32` consecutive 32-bit words. Output values never take a direct write. A write-one-to-set word drives bits high and a write-one-to-clear word drives them low, so several agents can touch disjoint pins without a read-modify-write. Edge status is sticky and is cleared by writing ones to it.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After synchronous reset, `pin_out`, `pin_oe` and `irq` are 0 and every readable word returns 0 while the pins are held low.
- R2: Function index order is level=0, direction=1, set=2, clear=3, rise-enable=4, fall-enable=5, status=6. A word's byte address is `fn*(NUM_PINS/32)*4 + (pin/32)*4`. The pin's bit inside that word is `pin%32`.
- R3: Writing a word of the set function raises `pin_out` for each 1 bit on the next clock edge and leaves pins under 0 bits unchanged. Reads of the set word return the output latch.
- R4: Writing a word of the clear function lowers `pin_out` for each 1 bit and leaves the others unchanged. Reads of the clear word also return the output latch.
- R5: The direction word is read/write, and `pin_oe` equals it (1 = output, 0 = input).
- R6: The level word returns `pin_in` after a two-flop synchronizer. Writes to it have no effect.
- R7: With its rise enable set, a 0-to-1 change on a pin sets its status bit on the third rising clock edge after the change.
- R8: With its fall enable set, a 1-to-0 change sets the status bit with the same latency. With both enables set, either edge sets it.
- R9: A transition on a pin whose matching enable is 0 leaves its status bit clear.
- R10: Writing 1 to a status bit clears it. Zero bits in that write leave status unchanged.
- R11: If an enabled edge is detected in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R12: `irq` is 1 exactly when any status bit in any word is set. It updates on the same edge as status.
- R13: Reads of an unmapped or misaligned address return 0. Writes to one change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rdata` loads on this edge |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, held between reads |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output enables (direction) |
| irq | output | 1 | Combined edge interrupt |

## Verification
A write takes effect on `pin_out`, `pin_oe` and the register contents at the clock edge that samples it. Read data is valid after the edge that samples `rd_en`. A pin change reaches the level word two edges after it is driven. It sets status and `irq` on the third edge. The bench drives stimulus on falling edges and counts rising edges before it samples. It checks that `irq` is still low after the second edge and high after the third. It also places a clear write on exactly the edge where an edge is detected, to exercise the collision rule.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W = 32;
  localparam int NUM_FN = 7;

  typedef enum logic [2:0] {
    FN_LEVEL = 3'd0,
    FN_DIR   = 3'd1,
    FN_SET   = 3'd2,
    FN_CLR   = 3'd3,
    FN_RISE  = 3'd4,
    FN_FALL  = 3'd5,
    FN_STAT  = 3'd6
  } gpio_fn_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NW     = 2,
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output gpio_fn_e          fn,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  localparam int WORD_AW = ADDR_W - 2;

  logic [WORD_AW-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    fn  = FN_LEVEL;
    idx = '0;
    hit = 1'b0;
    for (int f = 0; f < NUM_FN; f++) begin
      for (int w = 0; w < NW; w++) begin
        if (addr[1:0] == 2'b00 && word == WORD_AW'(f * NW + w)) begin
          fn  = gpio_fn_e'(3'(f));
          idx = IDX_W'(w);
          hit = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gpio_edge_word.sv
module gpio_edge_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status,
  output logic [W-1:0] status_next
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  assign hit         = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);
  assign status_next = (status & ~clr_mask) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      status <= '0;
    end else begin
      prev_q <= lvl;
      status <= status_next;
    end
  end

  // R7 / R8 / R11: a detected edge always leaves its bit set
  p_edge_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((status & $past(hit)) == $past(hit)));

  // R10: a cleared bit with no concurrent edge drops
  p_w1c_clears_r10: assert property (@(posedge clk) disable iff (rst)
    ((clr_mask & ~hit) != '0) |=> ((status & $past(clr_mask & ~hit)) == '0));

  // R9: a bit only rises on an enabled edge
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int NW       = NUM_PINS / WORD_W,
  parameter int ADDR_W   = $clog2(NUM_FN * NW * 4)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1;

  gpio_fn_e            fn;
  logic [IDX_W-1:0]    idx;
  logic                hit;
  logic [NUM_PINS-1:0] lvl_sync;
  logic [NUM_PINS-1:0] rise_q, fall_q;
  logic [NUM_PINS-1:0] status, status_next;
  logic [NW-1:0]       set_hit, clr_hit, dir_hit, stat_hit;

  gpio_addr_decode #(.NW(NW), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(addr), .fn(fn), .idx(idx), .hit(hit)
  );

  gpio_sync2 #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_sync)
  );

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic sel;
    assign sel         = wr_en && hit && (idx == IDX_W'(w));
    assign set_hit[w]  = sel && fn == FN_SET;
    assign clr_hit[w]  = sel && fn == FN_CLR;
    assign dir_hit[w]  = sel && fn == FN_DIR;
    assign stat_hit[w] = sel && fn == FN_STAT;

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[w*WORD_W +: WORD_W] <= '0;
        pin_oe [w*WORD_W +: WORD_W] <= '0;
        rise_q [w*WORD_W +: WORD_W] <= '0;
        fall_q [w*WORD_W +: WORD_W] <= '0;
      end else if (sel) begin
        case (fn)
          FN_DIR:  pin_oe [w*WORD_W +: WORD_W] <= wdata;
          FN_SET:  pin_out[w*WORD_W +: WORD_W] <= pin_out[w*WORD_W +: WORD_W] | wdata;
          FN_CLR:  pin_out[w*WORD_W +: WORD_W] <= pin_out[w*WORD_W +: WORD_W] & ~wdata;
          FN_RISE: rise_q [w*WORD_W +: WORD_W] <= wdata;
          FN_FALL: fall_q [w*WORD_W +: WORD_W] <= wdata;
          default: ;
        endcase
      end
    end

    gpio_edge_word #(.W(WORD_W)) u_edge (
      .clk        (clk),
      .rst        (rst),
      .lvl        (lvl_sync[w*WORD_W +: WORD_W]),
      .rise_en    (rise_q[w*WORD_W +: WORD_W]),
      .fall_en    (fall_q[w*WORD_W +: WORD_W]),
      .clr_mask   (stat_hit[w] ? wdata : '0),
      .status     (status[w*WORD_W +: WORD_W]),
      .status_next(status_next[w*WORD_W +: WORD_W])
    );

    // R3: every 1 written to the set word appears on pin_out
    p_set_high_r3: assert property (@(posedge clk) disable iff (rst)
      set_hit[w] |=> ((pin_out[w*WORD_W +: WORD_W] & $past(wdata)) == $past(wdata)));

    // R4: every 1 written to the clear word lowers pin_out
    p_clr_low_r4: assert property (@(posedge clk) disable iff (rst)
      clr_hit[w] |=> ((pin_out[w*WORD_W +: WORD_W] & $past(wdata)) == '0));
  end

  logic [WORD_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (hit) begin
      case (fn)
        FN_LEVEL:       rd_word = lvl_sync[idx*WORD_W +: WORD_W];
        FN_DIR:         rd_word = pin_oe  [idx*WORD_W +: WORD_W];
        FN_SET, FN_CLR: rd_word = pin_out [idx*WORD_W +: WORD_W];
        FN_RISE:        rd_word = rise_q  [idx*WORD_W +: WORD_W];
        FN_FALL:        rd_word = fall_q  [idx*WORD_W +: WORD_W];
        FN_STAT:        rd_word = status  [idx*WORD_W +: WORD_W];
        default:        rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_word;
      irq <= |status_next;
    end
  end

  // R5: direction only moves on a direction write
  p_oe_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (dir_hit == '0) |=> $stable(pin_oe));

  // R12: interrupt tracks the OR of all status words
  p_irq_any_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq == (|status)));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
  localparam int NUM_PINS = 64;
  localparam int NW       = NUM_PINS / 32;
  localparam int ADDR_W   = $clog2(7 * NW * 4);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NUM_PINS-1:0] pin_in = '0;
  logic [NUM_PINS-1:0] pin_out, pin_oe;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NUM_PINS)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // Byte addresses (NW=2): level 00/04 dir 08/0C set 10/14 clr 18/1C
  // rise 20/24 fall 28/2C status 30/34; 38 and up unmapped.
  // Entry: {is_read, addr[7:0], wdata, expected}
  localparam int NV = 17;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h08, 32'h0000FFFF, 32'h0},          // R5 direction write
    {1'b1, 8'h08, 32'h0,        32'h0000FFFF},   // R5 readback
    {1'b1, 8'h0C, 32'h0,        32'h00000000},   // R2 other word untouched
    {1'b0, 8'h10, 32'hA5A5A5A5, 32'h0},          // R3 set
    {1'b1, 8'h10, 32'h0,        32'hA5A5A5A5},   // R3
    {1'b1, 8'h18, 32'h0,        32'hA5A5A5A5},   // R4 clear word reads latch
    {1'b0, 8'h10, 32'h0000000F, 32'h0},          // R3 zeros keep
    {1'b1, 8'h10, 32'h0,        32'hA5A5A5AF},   // R3
    {1'b0, 8'h14, 32'hFFFFFFFF, 32'h0},          // R2 upper word
    {1'b0, 8'h1C, 32'h0F0F0000, 32'h0},          // R4
    {1'b1, 8'h14, 32'h0,        32'hF0F0FFFF},   // R4
    {1'b0, 8'h18, 32'h000000A5, 32'h0},          // R4
    {1'b1, 8'h10, 32'h0,        32'hA5A5A50A},   // R4
    {1'b0, 8'h38, 32'hFFFFFFFF, 32'h0},          // R13 unmapped write
    {1'b1, 8'h38, 32'h0,        32'h00000000},   // R13 unmapped read
    {1'b0, 8'h12, 32'hFFFFFFFF, 32'h0},          // R13 misaligned write
    {1'b1, 8'h10, 32'h0,        32'hA5A5A50A}    // R13 latch unchanged
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    addr = ADDR_W'(a); rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    check(req, {32'h0, rdata}, {32'h0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_oe", pin_oe, '0);
    check("R1 irq", {63'h0, irq}, 64'h0);
    for (int a = 0; a < 14; a++) rd_chk("R1 regs", 8'(a * 4), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) rd_chk("R2-table read", VEC[i][71:64], VEC[i][31:0]);
      else            wr(VEC[i][71:64], VEC[i][63:32]);
    end
    check("R3 pins", pin_out, 64'hF0F0FFFF_A5A5A50A);
    check("R5 oe", pin_oe, 64'h00000000_0000FFFF);

    // R6 level readback through synchronizer, writes ignored
    pin_in = 64'h12345678_9ABCDEF0;
    tick(); tick();
    rd_chk("R6 level lo", 8'h00, 32'h9ABCDEF0);
    rd_chk("R6 level hi", 8'h04, 32'h12345678);
    wr(8'h00, 32'h0);
    rd_chk("R6 level write ignored", 8'h00, 32'h9ABCDEF0);
    rd_chk("R9 no status without enable", 8'h30, 32'h0);
    check("R9 irq", {63'h0, irq}, 64'h0);
    pin_in = '0;
    tick(); tick(); tick();

    // R7 rising edge on pin 32, latency three edges
    wr(8'h24, 32'h1);
    pin_in[32] = 1'b1;
    tick(); tick();
    check("R7 irq before 3rd edge", {63'h0, irq}, 64'h0);
    tick();
    check("R7 irq on 3rd edge", {63'h0, irq}, 64'h1);
    rd_chk("R7 status hi", 8'h34, 32'h1);
    rd_chk("R12 status lo word", 8'h30, 32'h0);
    // R10 write-one-to-clear
    wr(8'h34, 32'h0);
    rd_chk("R10 zero write keeps", 8'h34, 32'h1);
    wr(8'h34, 32'h1);
    rd_chk("R10 cleared", 8'h34, 32'h0);
    check("R12 irq low", {63'h0, irq}, 64'h0);
    // R9 falling edge on pin 32 not enabled
    pin_in[32] = 1'b0;
    tick(); tick(); tick();
    rd_chk("R9 fall not enabled", 8'h34, 32'h0);

    // R8 falling edge on pin 5
    wr(8'h28, 32'h20);
    pin_in[5] = 1'b1;
    tick(); tick(); tick();
    rd_chk("R9 rise not enabled", 8'h30, 32'h0);
    pin_in[5] = 1'b0;
    tick(); tick(); tick();
    rd_chk("R8 fall status", 8'h30, 32'h20);
    check("R12 irq high", {63'h0, irq}, 64'h1);
    wr(8'h30, 32'h20);

    // R8 both edges on pin 7
    wr(8'h20, 32'h80);
    wr(8'h28, 32'hA0);
    pin_in[7] = 1'b1;
    tick(); tick(); tick();
    rd_chk("R8 both rise", 8'h30, 32'h80);
    wr(8'h30, 32'h80);
    pin_in[7] = 1'b0;
    tick(); tick(); tick();
    rd_chk("R8 both fall", 8'h30, 32'h80);

    // R11 clear collides with a new edge: edge wins
    pin_in[7] = 1'b1;
    tick(); tick();
    wr(8'h30, 32'h80);
    rd_chk("R11 edge wins", 8'h30, 32'h80);
    check("R11 irq", {63'h0, irq}, 64'h1);
    wr(8'h30, 32'h80);
    rd_chk("R10 plain clear", 8'h30, 32'h0);
    check("R12 irq drops", {63'h0, irq}, 64'h0);

    // R1 reset again clears everything
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 reapply out", pin_out, '0);
    check("R1 reapply oe", pin_oe, '0);
    rd_chk("R1 rise cleared", 8'h20, 32'h0);

    finish_run();
  end
endmodule